// File: doc/BRIEF.md
# Wait-State Acknowledge Generator

This block produces the active-low data-transfer acknowledge for an asynchronous bus in which the master asserts an active-low address strobe and then waits for the acknowledge. Each chip select on the bus has a fixed number of wait states, set at build time. The block counts the rising clock edges since the strobe fell. It does this with a single shared shift chain whose serial input is tied to one. The chain is held in synchronous clear whenever the strobe is high, so every stage reads zero between bus cycles.

Stage `n` of the chain becomes one on the `(n+1)`th rising edge after the strobe falls. A select with `n` wait states is gated by stage `n`. The gated terms are ORed, registered and inverted to drive the acknowledge. Once the acknowledge is asserted it holds until the strobe returns high. After that, the next rising edge clears it, in time for the next bus cycle. If no select is active, the acknowledge is never asserted, so bus-error timeout logic elsewhere can detect the access.

Top module: `dtack_waitgen`

## Requirements
- R1: A select configured with zero wait states, sampled active at the first rising edge after the strobe falls, drives `ack_n` low directly after that edge.
- R2: A select configured with `n` wait states drives `ack_n` low directly after the `(n+1)`th rising edge of the strobe-low period, not before. With the default map, select `i` has `i` wait states (`i` = 0..7).
- R3: When several selects are active together, `ack_n` falls at the earliest point permitted by any of them.
- R4: While the strobe is high, `ack_n` stays high and the count stages all read zero, including before the first bus cycle.
- R5: If no select is active at any edge of the strobe-low period, `ack_n` stays high for the whole bus cycle.
- R6: At the first rising edge where the strobe is sampled high, `ack_n` returns high directly after that edge.
- R7: Once `ack_n` is low, it stays low for as long as the strobe stays low, even if every select drops.
- R8: A select that first becomes active after its own wait count has already elapsed drives `ack_n` low directly after the first edge at which it is sampled active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| as_n | input | 1 | Address strobe, active low; high holds the count chain and acknowledge cleared |
| cs | input | N_SEL | Decoded chip selects, active high, one per device |
| ack_n | output | 1 | Data-transfer acknowledge, active low, registered |

## Verification
The assertions assume that the strobe is a clean synchronous level at each rising edge and that it stays high for at least one edge between bus cycles. There is no reset pin, so the design state is known only after the strobe has been sampled high once. The bench therefore holds the strobe high for several edges at start-up. It changes the strobe and the selects only at falling edges, and it always ends a bus cycle with one or more high-strobe edges. Random cycles vary the select patterns in the middle of the cycle. Directed cycles cover the empty-select case, late arrival and early withdrawal.

// File: rtl/dtack_pkg.sv
package dtack_pkg;
    parameter int unsigned DEF_N_SEL  = 8;
    parameter int unsigned DEF_MAX_WS = 7;

    typedef struct packed {
        logic ack;
    } ack_state_t;
endpackage

// File: rtl/dtack_shift_chain.sv
module dtack_shift_chain #(
    parameter int unsigned MAX_WS = dtack_pkg::DEF_MAX_WS,
    localparam int unsigned STAGES = MAX_WS + 1
) (
    input  logic              clk,
    input  logic              as_n,
    output logic [STAGES-1:0] tap_q,
    output logic [STAGES-1:0] tap_d
);
    // ones enter at stage 0 and walk upward while the strobe is low
    always_comb begin
        if (as_n) tap_d = '0;
        else      tap_d = (tap_q << 1) | STAGES'(1);
    end

    always_ff @(posedge clk) begin
        tap_q <= tap_d;
    end

    p_idle_clear_r4: assert property (@(posedge clk) as_n |=> (tap_q == '0));
    p_first_edge_r1: assert property (@(posedge clk) !as_n |=> tap_q[0]);
    p_thermo_r2:     assert property (@(posedge clk) !as_n |=> (((tap_q >> 1) & ~tap_q) == '0));
endmodule

// File: rtl/dtack_tap_select.sv
module dtack_tap_select #(
    parameter int unsigned N_SEL  = dtack_pkg::DEF_N_SEL,
    parameter int unsigned MAX_WS = dtack_pkg::DEF_MAX_WS,
    parameter int unsigned WS_TABLE [N_SEL] = '{0, 1, 2, 3, 4, 5, 6, 7},
    localparam int unsigned STAGES = MAX_WS + 1
) (
    input  logic [STAGES-1:0] tap,
    input  logic [N_SEL-1:0]  cs,
    output logic              hit
);
    logic [N_SEL-1:0] gated;

    for (genvar i = 0; i < N_SEL; i++) begin : g_sel
        localparam int unsigned WS_I = (WS_TABLE[i] > MAX_WS) ? MAX_WS : WS_TABLE[i];
        assign gated[i] = cs[i] & tap[WS_I];
    end

    assign hit = |gated;
endmodule

// File: rtl/dtack_waitgen.sv
module dtack_waitgen #(
    parameter int unsigned N_SEL  = dtack_pkg::DEF_N_SEL,
    parameter int unsigned MAX_WS = dtack_pkg::DEF_MAX_WS,
    parameter int unsigned WS_TABLE [N_SEL] = '{0, 1, 2, 3, 4, 5, 6, 7}
) (
    input  logic             clk,
    input  logic             as_n,
    input  logic [N_SEL-1:0] cs,
    output logic             ack_n
);
    import dtack_pkg::*;

    localparam int unsigned STAGES = MAX_WS + 1;

    logic [STAGES-1:0] tap_q;
    logic [STAGES-1:0] tap_d;
    logic              hit_d;
    ack_state_t        st_d;
    ack_state_t        st_q;

    dtack_shift_chain #(.MAX_WS(MAX_WS)) u_chain (
        .clk   (clk),
        .as_n  (as_n),
        .tap_q (tap_q),
        .tap_d (tap_d)
    );

    // selects are matched against the taps the coming edge will load
    dtack_tap_select #(
        .N_SEL    (N_SEL),
        .MAX_WS   (MAX_WS),
        .WS_TABLE (WS_TABLE)
    ) u_sel (
        .tap (tap_d),
        .cs  (cs),
        .hit (hit_d)
    );

    always_comb begin
        st_d = st_q;
        if (as_n) st_d.ack = 1'b0;
        else      st_d.ack = st_q.ack | hit_d;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ack_n = ~st_q.ack;

    p_idle_high_r4: assert property (@(posedge clk) as_n |=> ack_n);
    p_release_r6:   assert property (@(posedge clk) as_n |=> ack_n);
    p_hold_r7:      assert property (@(posedge clk) (!as_n && !ack_n) |=> !ack_n);
    p_no_sel_r5:    assert property (@(posedge clk) (!as_n && ack_n && (cs == '0)) |=> ack_n);
    p_zero_ws_r1:   assert property (@(posedge clk) (!as_n && cs[0]) |=> !ack_n);
endmodule

// File: tb/dtack_waitgen_tb.sv
module dtack_waitgen_tb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned N_SEL = 8;
    localparam int unsigned MAX_WS = 7;

    logic clk = 1'b0;
    logic as_n = 1'b1;
    logic [N_SEL-1:0] cs = '0;
    logic ack_n;

    int checks = 0;
    int fails = 0;
    bit model_ack;
    int edge_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtack_waitgen u_dut (.clk(clk), .as_n(as_n), .cs(cs), .ack_n(ack_n));

    // default map: select i has i wait states
    function automatic bit may_ack(logic [N_SEL-1:0] sel, int j);
        for (int i = 0; i < N_SEL; i++)
            if (sel[i] && j >= i) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(logic got, logic exp, string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: ack_n=%b expected %b (edge %0d)", req, got, exp, edge_idx);
        end
    endtask

    // open a bus cycle with the given selects (called at a falling edge)
    task automatic start_cycle(logic [N_SEL-1:0] sel);
        as_n = 1'b0;
        cs = sel;
        model_ack = 1'b0;
        edge_idx = 0;
    endtask

    // one rising edge inside the cycle, then sample at the falling edge
    task automatic step(string req);
        @(posedge clk);
        model_ack = model_ack | may_ack(cs, edge_idx);
        @(negedge clk);
        check(ack_n, ~model_ack, req);
        edge_idx++;
    endtask

    task automatic end_cycle();
        as_n = 1'b1;
        cs = '0;
        @(posedge clk);
        @(negedge clk);
        check(ack_n, 1'b1, "R6");
        @(posedge clk);
        @(negedge clk);
        check(ack_n, 1'b1, "R4");
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        checks++;
        $display("FAIL watchdog: ack_n=%b expected completion", ack_n);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        edge_idx = 0;
        repeat (3) @(negedge clk);
        check(ack_n, 1'b1, "R4");

        // R1: zero wait states
        start_cycle(8'b0000_0001);
        step("R1");
        step("R1");
        end_cycle();

        // R2: every wait count alone
        for (int w = 0; w < N_SEL; w++) begin
            start_cycle(N_SEL'(1) << w);
            for (int k = 0; k < w + 2; k++) step("R2");
            end_cycle();
        end

        // R3: several selects together
        start_cycle(8'b1010_0100);
        for (int k = 0; k < 5; k++) step("R3");
        end_cycle();

        // R5: nothing selected
        start_cycle('0);
        for (int k = 0; k < MAX_WS + 3; k++) step("R5");
        end_cycle();

        // R7: select withdrawn after acknowledge
        start_cycle(8'b0000_1000);
        for (int k = 0; k < 4; k++) step("R7");
        cs = '0;
        for (int k = 0; k < 3; k++) step("R7");
        end_cycle();

        // R8: select arrives after its count has elapsed
        start_cycle('0);
        for (int k = 0; k < 5; k++) step("R8");
        cs = 8'b0000_0100;
        for (int k = 0; k < 2; k++) step("R8");
        end_cycle();

        // random cycles with selects changing mid-cycle
        for (int n = 0; n < 200; n++) begin
            start_cycle(N_SEL'($urandom));
            if ($urandom_range(0, 3) == 0) cs = '0;
            for (int k = 0; k < int'($urandom_range(1, 12)); k++) begin
                step("R3");
                if ($urandom_range(0, 2) == 0) cs = N_SEL'($urandom) & N_SEL'($urandom);
            end
            end_cycle();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule